// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox

This block passes bytes in both directions between an external host bus and an on-chip slave processor. The host writes into an inbound data register, which the slave then reads. The slave writes into an outbound data register, which the host then reads. A status byte shows the state of both registers. It holds an inbound-full flag, an outbound-full flag and a command/data flag. The command/data flag records which host address the last host write used. The inbound-full flag also serves as the slave's interrupt request.

The host side is asynchronous. It has an active-low chip select, one address bit, and active-low read and write strobes. Both strobes are synchronized into the slave clock domain. Every flag change caused by the host takes effect when a host strobe ends. The slave side is a synchronous register port with single-cycle read and write pulses. A slave access takes effect on the clock edge that ends its cycle. When the same flag is set and cleared in one slave clock cycle, the set wins.

Top module: `hs_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00 from both sides and `sl_irq` is low.
- R2: A host write, with `host_a0` either 0 or 1, loads the inbound register from `host_wdata` and sets the inbound-full flag (status bit 1) when `host_wr_n` returns high. The flag becomes visible on the third slave clock edge after the release.
- R3: Every host write sets the command/data flag (status bit 3) to the value of `host_a0` at the end of the write. Nothing else changes this flag.
- R4: A slave read at `sl_addr` 0 returns the inbound register and clears the inbound-full flag.
- R5: A slave write at `sl_addr` 1 loads the outbound register and sets the outbound-full flag (status bit 0).
- R6: A host read with `host_a0` = 0 returns the outbound register. The outbound-full flag stays set while `host_rd_n` is low and clears after the strobe returns high.
- R7: The status byte has command/data in bit 3, inbound-full in bit 1, outbound-full in bit 0 and zeros in all other bits. A host read with `host_a0` = 1 returns it, and so does a slave read at `sl_addr` 2.
- R8: A slave write at `sl_addr` 2 with bit 0 = 0 clears outbound-full. If bit 0 is 1 the write has no effect, and bits 1 and 3 of the written value are always ignored.
- R9: If a flag is set and cleared in the same slave clock cycle, it ends up set.
- R10: `sl_irq` is high exactly while inbound-full is set.
- R11: Host strobes pulsed while `host_cs_n` is high change no register or flag, and `host_rdata` reads zero outside an active host read. A slave read at `sl_addr` 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Host address bit |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| sl_rd | input | 1 | Slave read pulse |
| sl_wr | input | 1 | Slave write pulse |
| sl_addr | input | 2 | Slave register select |
| sl_wdata | input | DATA_W | Slave write data |
| sl_rdata | output | DATA_W | Slave read data |
| sl_irq | output | 1 | Interrupt request to the slave (inbound full) |

## Verification
The bench times host strobe releases so that they land in the same slave cycle as a conflicting slave access. A design with clear-over-set priority would then lose a host byte, or hide a freshly written outbound byte from the host.

It checks the exact synchronizer latency and holds a host read strobe low while it polls status. A design that updates flags when the strobe starts would clear outbound-full while the host is still reading. It also checks a design with the wrong pipeline depth.

It writes the status byte with bits that must be ignored. A design with a writable inbound-full or command/data bit, or one that sets outbound-full from a status write, would corrupt the handshake. Finally, it pulses strobes with the chip select inactive to expose any design that does not qualify strobes with the chip select.

// File: rtl/mbx_pkg.sv
// Package: shared constants and types for the host/slave mailbox.
// Assumes DATA_W of at least 4 so that every status bit position exists.
package mbx_pkg;
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;

    typedef enum logic [1:0] {
        SL_IDR  = 2'd0,
        SL_ODR  = 2'd1,
        SL_STAT = 2'd2,
        SL_NONE = 2'd3
    } sl_reg_e;

    typedef struct packed {
        logic ibf;
        logic obf;
        logic cd;
    } flags_t;
endpackage

// File: rtl/mbx_strobe_sync.sv
// Module: brings an asynchronous active-high strobe into the clock domain
// through STAGES flops and pulses for one cycle when the strobe ends.
// Assumes the strobe stays active for at least STAGES+1 clock periods.
module mbx_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_act,
    output logic release_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single-flop capture of the strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= strobe_act;
            end
        end else begin : g_multi
            // Purpose: shift the strobe through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], strobe_act};
            end
        end
    endgenerate

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign release_pulse = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/mbx_flags.sv
// Module: holds the three mailbox flags. A set beats a clear when both
// arrive in the same cycle. Assumes every input is a single-cycle pulse
// in the clock domain.
module mbx_flags
    import mbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   host_wr_done,
    input  logic   host_cd_bit,
    input  logic   host_odr_rd_done,
    input  logic   sl_idr_read,
    input  logic   sl_odr_write,
    input  logic   sl_obf_clear,
    output flags_t flags
);
    // Purpose: inbound-full is set by a host write and cleared by a slave read.
    always_ff @(posedge clk) begin
        if (!rst_n)            flags.ibf <= 1'b0;
        else if (host_wr_done) flags.ibf <= 1'b1;
        else if (sl_idr_read)  flags.ibf <= 1'b0;
    end

    // Purpose: outbound-full is set by a slave write and cleared by a host read or a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                               flags.obf <= 1'b0;
        else if (sl_odr_write)                    flags.obf <= 1'b1;
        else if (host_odr_rd_done || sl_obf_clear) flags.obf <= 1'b0;
    end

    // Purpose: command/data records the host address bit of each host write.
    always_ff @(posedge clk) begin
        if (!rst_n)            flags.cd <= 1'b0;
        else if (host_wr_done) flags.cd <= host_cd_bit;
    end
endmodule

// File: rtl/hs_mailbox.sv
// Module: top of the mailbox. Synchronizes the host strobes, holds the two
// data registers, decodes both ports and builds the status byte.
// Assumes the host keeps cs, address and write data stable until
// SYNC_STAGES+2 slave clocks after a strobe returns high.
module hs_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_a0,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sl_rd,
    input  logic              sl_wr,
    input  logic [1:0]        sl_addr,
    input  logic [DATA_W-1:0] sl_wdata,
    output logic [DATA_W-1:0] sl_rdata,
    output logic              sl_irq
);
    logic              wr_act, rd_act;
    logic              wr_done, rd_done;
    logic [DATA_W-1:0] idr_q, odr_q, status_w;
    flags_t            flags;
    sl_reg_e           sl_sel;

    assign wr_act = ~host_cs_n & ~host_wr_n;
    assign rd_act = ~host_cs_n & ~host_rd_n;
    assign sl_sel = sl_reg_e'(sl_addr);

    mbx_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_act(wr_act), .release_pulse(wr_done)
    );

    mbx_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_act(rd_act), .release_pulse(rd_done)
    );

    mbx_flags u_flags (
        .clk              (clk),
        .rst_n            (rst_n),
        .host_wr_done     (wr_done),
        .host_cd_bit      (host_a0),
        .host_odr_rd_done (rd_done & ~host_a0),
        .sl_idr_read      (sl_rd & (sl_sel == SL_IDR)),
        .sl_odr_write     (sl_wr & (sl_sel == SL_ODR)),
        .sl_obf_clear     (sl_wr & (sl_sel == SL_STAT) & ~sl_wdata[ST_OBF]),
        .flags            (flags)
    );

    // Purpose: load the inbound register when a host write ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       idr_q <= '0;
        else if (wr_done) idr_q <= host_wdata;
    end

    // Purpose: load the outbound register on a slave write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          odr_q <= '0;
        else if (sl_wr && sl_sel == SL_ODR)  odr_q <= sl_wdata;
    end

    // Purpose: assemble the status byte from the flags.
    always_comb begin
        status_w         = '0;
        status_w[ST_CD]  = flags.cd;
        status_w[ST_IBF] = flags.ibf;
        status_w[ST_OBF] = flags.obf;
    end

    // Purpose: slave read-data multiplexer.
    always_comb begin
        case (sl_sel)
            SL_IDR:  sl_rdata = idr_q;
            SL_ODR:  sl_rdata = odr_q;
            SL_STAT: sl_rdata = status_w;
            default: sl_rdata = '0;
        endcase
    end

    // Purpose: host read-data multiplexer, zero outside an active read.
    always_comb begin
        if (rd_act) host_rdata = host_a0 ? status_w : odr_q;
        else        host_rdata = '0;
    end

    assign sl_irq = flags.ibf;
endmodule

// File: rtl/mbx_checker.sv
// Module: property checker bound into hs_mailbox. It watches the internal
// strobe-release pulses, the flags and the slave port.
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sl_rd,
    input logic              sl_wr,
    input logic [1:0]        sl_addr,
    input logic [DATA_W-1:0] sl_wdata,
    input logic              wr_done,
    input logic              host_a0,
    input flags_t            flags
);
    a_r2_ibf_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> flags.ibf);

    a_r4_ibf_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_rd && sl_addr == 2'd0 && !wr_done) |=> !flags.ibf);

    a_r5_obf_after_odr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_wr && sl_addr == 2'd1) |=> flags.obf);

    a_r5_obf_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.obf) |-> $past(sl_wr && sl_addr == 2'd1));

    a_r8_obf_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_wr && sl_addr == 2'd2 && !sl_wdata[ST_OBF]) |=> !flags.obf);

    a_r3_cd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> $stable(flags.cd));

    a_r3_cd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (flags.cd == $past(host_a0)));
endmodule

bind hs_mailbox mbx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sl_rd    (sl_rd),
    .sl_wr    (sl_wr),
    .sl_addr  (sl_addr),
    .sl_wdata (sl_wdata),
    .wr_done  (wr_done),
    .host_a0  (host_a0),
    .flags    (flags)
);

// File: tb/hs_mailbox_tb.sv
module hs_mailbox_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1, host_a0 = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       sl_rd = 1'b0, sl_wr = 1'b0;
    logic [1:0] sl_addr = '0;
    logic [7:0] sl_wdata = '0, sl_rdata;
    logic       sl_irq;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] q;

    // Host write vectors: {host_a0, data}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'h12}, {1'b1, 8'hA4}, {1'b1, 8'h00},
        {1'b0, 8'hFF}, {1'b1, 8'h5A}, {1'b0, 8'h81}
    };

    always #4 clk = ~clk;

    hs_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_a0(host_a0),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .sl_rd(sl_rd), .sl_wr(sl_wr), .sl_addr(sl_addr),
        .sl_wdata(sl_wdata), .sl_rdata(sl_rdata), .sl_irq(sl_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sl_access(input logic w, input logic [1:0] a, input logic [7:0] d,
                             output logic [7:0] r);
        @(negedge clk);
        sl_wr = w; sl_rd = ~w; sl_addr = a; sl_wdata = d;
        #1 r = sl_rdata;
        @(negedge clk);
        sl_wr = 1'b0; sl_rd = 1'b0;
    endtask

    task automatic host_write(input logic a, input logic [7:0] d, input logic cs);
        @(negedge clk);
        host_a0 = a; host_wdata = d; host_cs_n = ~cs; host_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1;
    endtask

    task automatic host_read(input logic a, input logic cs, output logic [7:0] r);
        @(negedge clk);
        host_a0 = a; host_cs_n = ~cs; host_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 r = host_rdata;
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {7'd0, sl_irq}, 8'h00);
        sl_access(1'b0, 2'd2, 8'h00, q); check("R1 slave status", q, 8'h00);
        host_read(1'b1, 1'b1, q);        check("R1 host status", q, 8'h00);

        // Vector walk: R2, R3, R4, R7, R10
        for (int i = 0; i < 6; i++) begin
            host_write(VEC[i][8], VEC[i][7:0], 1'b1);
            check("R10 irq after write", {7'd0, sl_irq}, 8'h01);
            host_read(1'b1, 1'b1, q);
            check("R7 R3 host status", q, {4'd0, VEC[i][8], 3'b010});
            sl_access(1'b0, 2'd0, 8'h00, q);
            check("R2 R4 inbound data", q, VEC[i][7:0]);
            check("R4 irq cleared", {7'd0, sl_irq}, 8'h00);
        end

        // R2 exact latency: flag shows on the third edge after release
        @(negedge clk);
        host_a0 = 1'b0; host_wdata = 8'h3C; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 not yet after two edges", {7'd0, sl_irq}, 8'h00);
        @(negedge clk);
        check("R2 set on third edge", {7'd0, sl_irq}, 8'h01);
        repeat (2) @(negedge clk);
        host_cs_n = 1'b1;
        sl_access(1'b0, 2'd0, 8'h00, q);
        check("R2 latency data", q, 8'h3C);

        // R5 / R6 outbound path, flag held during host strobe
        sl_access(1'b1, 2'd1, 8'hA5, q);
        sl_access(1'b0, 2'd2, 8'h00, q); check("R5 obf set", q, 8'h01);
        @(negedge clk);
        host_a0 = 1'b0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R6 host outbound data", host_rdata, 8'hA5);
        sl_access(1'b0, 2'd2, 8'h00, q); check("R6 obf held during strobe", q, 8'h01);
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = 1'b1;
        sl_access(1'b0, 2'd2, 8'h00, q); check("R6 obf cleared after strobe", q, 8'h00);

        // R8 status writes
        host_write(1'b1, 8'h77, 1'b1);
        sl_access(1'b1, 2'd1, 8'h11, q);
        sl_access(1'b1, 2'd2, 8'hFF, q);
        sl_access(1'b0, 2'd2, 8'h00, q); check("R8 bit0 one no effect", q, 8'h0B);
        sl_access(1'b1, 2'd2, 8'h00, q);
        sl_access(1'b0, 2'd2, 8'h00, q); check("R8 clear obf only", q, 8'h0A);
        sl_access(1'b0, 2'd0, 8'h00, q); check("R4 inbound 77", q, 8'h77);

        // R9 inbound set beats slave read in the same cycle
        @(negedge clk);
        host_a0 = 1'b0; host_wdata = 8'h44; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        sl_rd = 1'b1; sl_addr = 2'd0;
        @(negedge clk);
        sl_rd = 1'b0;
        check("R9 ibf set wins", {7'd0, sl_irq}, 8'h01);
        repeat (2) @(negedge clk);
        host_cs_n = 1'b1;
        sl_access(1'b0, 2'd0, 8'h00, q); check("R9 inbound data kept", q, 8'h44);

        // R9 outbound set beats host read end in the same cycle
        sl_access(1'b1, 2'd1, 8'h01, q);
        @(negedge clk);
        host_a0 = 1'b0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        host_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        sl_wr = 1'b1; sl_addr = 2'd1; sl_wdata = 8'h99;
        @(negedge clk);
        sl_wr = 1'b0;
        repeat (2) @(negedge clk);
        host_cs_n = 1'b1;
        sl_access(1'b0, 2'd2, 8'h00, q); check("R9 obf set wins", q, 8'h01);

        // R11 strobes without chip select
        host_write(1'b1, 8'hEE, 1'b0);
        check("R11 irq stays low", {7'd0, sl_irq}, 8'h00);
        host_read(1'b0, 1'b0, q); check("R11 rdata zero", q, 8'h00);
        sl_access(1'b0, 2'd2, 8'h00, q); check("R11 status unchanged", q, 8'h01);
        sl_access(1'b0, 2'd0, 8'h00, q); check("R11 inbound unchanged", q, 8'h44);
        sl_access(1'b0, 2'd3, 8'h00, q); check("R11 unused address", q, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule